// File: doc/BRIEF.md
# Serial Bit-Position Counter with Acknowledge

This block tracks the bit position inside a serial transfer for a port that can run either as a two-wire bus with an acknowledge bit or as a plain clocked shift interface. It brings the externally sampled shift clock and data line into the system clock domain. It counts rising shift-clock edges and returns to zero after a terminal value. That value is 9 in bus mode and 8 in shift mode.

In bus mode the block also handles the acknowledge bit, which it keeps in a register that software can write.

- **Receiving:** the register's value is driven onto the data line during the ninth clock, through an open-drain pull-low enable.
- **Transmitting:** the data line level on the ninth rising edge is captured into the same register.

A freeze input from the wait logic stops all edge-driven activity. Several events clear the counter:

- a start-condition pulse,
- a clock-stop command,
- a switch from bus mode to shift mode.

Top module: `ser_bitcnt`

## Requirements
- R1: After synchronous reset, `bit_cnt` is 0, `ack_bit` is 1 and `sda_pull_low` is 0.
- R2: Each rising edge of `scl_in` that is not frozen increments `bit_cnt` by one. The new value appears on the third system clock edge after `scl_in` changes: two synchronizer flops, then the edge compare.
- R3: With `i2c_mode`=1, a rising edge seen while `bit_cnt` is 9 returns it to 0, so the count never exceeds 9.
- R4: With `i2c_mode`=0, a rising edge seen while `bit_cnt` is 8 returns it to 0, so the count never exceeds 8.
- R5: A one-cycle `start_det` or `clk_stop` pulse clears `bit_cnt` to 0 on the next clock edge.
- R6: A change of `i2c_mode` from 1 to 0 clears `bit_cnt` on the next clock edge. A change from 0 to 1 leaves it unchanged.
- R7: While `freeze` is 1, shift-clock edges change neither `bit_cnt` nor the acknowledge logic.
- R8: In bus mode with `rx_dir`=0 (transmit), the synchronized data level at the rising edge that takes `bit_cnt` from 8 to 9 is stored in `ack_bit`. Other rising edges do not change it.
- R9: In bus mode with `rx_dir`=1 (receive), the acknowledge window opens at the falling edge seen while `bit_cnt` is 8. It closes at the falling edge seen while `bit_cnt` is 9. Inside the window, `sda_pull_low` is 1 exactly when `ack_bit` is 0.
- R10: A write pulse on `ack_wr_en` loads `ack_wr_val` into `ack_bit`. That value is held until the next write or transmit capture.
- R11: With `i2c_mode`=0, the acknowledge logic is inactive. `ack_bit` is not captured and `sda_pull_low` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Shift clock line level (asynchronous) |
| sda_in | input | 1 | Data line level (asynchronous) |
| i2c_mode | input | 1 | 1 = two-wire bus mode, 0 = shift mode |
| rx_dir | input | 1 | 1 = receive, 0 = transmit |
| start_det | input | 1 | Start condition detected, one-cycle pulse |
| clk_stop | input | 1 | Clock-stop command, one-cycle pulse |
| freeze | input | 1 | Hold counter and acknowledge logic |
| ack_wr_en | input | 1 | Write strobe for the acknowledge register |
| ack_wr_val | input | 1 | Value written to the acknowledge register |
| bit_cnt | output | CNT_W | Current bit position |
| ack_bit | output | 1 | Acknowledge register |
| sda_pull_low | output | 1 | Open-drain pull-low enable for the data line |

## Verification
The main patterns are full frames of 9 and 10 clock pulses, in each mode. These show whether the wrap happens at the mode's own terminal value and whether it shows up one edge early or late. Receive frames are run with the register at 0 and at 1, and transmit frames with the line low and high. This separates driving from sampling, and it checks that the window opens and closes on the right falling edges. The clear triggers are applied mid-frame, and the mode is switched in both directions. This shows which events reset the count and which leave it alone. Pulses sent under freeze, and frames run in shift mode, confirm that edges are ignored and that the acknowledge logic stays off.

// File: rtl/ser_bitcnt.sv
module ser_bitcnt #(
  parameter int CNT_W     = 4,
  parameter int BUS_LAST  = 9,
  parameter int SHF_LAST  = 8,
  parameter bit ACK_RST   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             i2c_mode,
  input  logic             rx_dir,
  input  logic             start_det,
  input  logic             clk_stop,
  input  logic             freeze,
  input  logic             ack_wr_en,
  input  logic             ack_wr_val,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             ack_bit,
  output logic             sda_pull_low
);
  localparam logic [CNT_W-1:0] L_BUS  = CNT_W'(BUS_LAST);
  localparam logic [CNT_W-1:0] L_SHF  = CNT_W'(SHF_LAST);
  localparam logic [CNT_W-1:0] L_ACKW = CNT_W'(BUS_LAST - 1);

  logic [1:0]       scl_sync, sda_sync;
  logic             scl_q, mode_q, ack_q, drv_q;
  logic [CNT_W-1:0] cnt_q;

  wire rise  = scl_sync[1] & ~scl_q & ~freeze;
  wire fall  = ~scl_sync[1] & scl_q & ~freeze;
  wire clr   = start_det | clk_stop | (mode_q & ~i2c_mode);
  wire [CNT_W-1:0] last = i2c_mode ? L_BUS : L_SHF;
  wire ack_on = i2c_mode & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '0;
      sda_sync <= '1;
      scl_q    <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_sync[1];
      mode_q   <= i2c_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (rise)
      cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ack_q <= ACK_RST;
    else if (ack_wr_en)
      ack_q <= ack_wr_val;
    else if (ack_on && !rx_dir && rise && cnt_q == L_ACKW)
      ack_q <= sda_sync[1];
  end

  always_ff @(posedge clk) begin
    if (rst || !ack_on || !rx_dir)
      drv_q <= 1'b0;
    else if (fall && cnt_q == L_ACKW)
      drv_q <= 1'b1;
    else if (fall && cnt_q == L_BUS)
      drv_q <= 1'b0;
  end

  assign bit_cnt      = cnt_q;
  assign ack_bit      = ack_q;
  assign sda_pull_low = drv_q & ~ack_q;
endmodule

module ser_bitcnt_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             i2c_mode,
  input logic             start_det,
  input logic             clk_stop,
  input logic             freeze,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sda_pull_low
);
  logic mode_seen;
  always_ff @(posedge clk) mode_seen <= rst ? 1'b0 : i2c_mode;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt != $past(bit_cnt) && bit_cnt != '0) |-> bit_cnt == $past(bit_cnt) + 1'b1);
  // R3
  bus_limit_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(9));
  // R4
  shf_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (!i2c_mode && !mode_seen) |-> bit_cnt <= CNT_W'(8));
  // R5
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det || clk_stop) |=> bit_cnt == '0);
  // R6
  mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_seen && !i2c_mode) |=> bit_cnt == '0);
  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freeze && !start_det && !clk_stop && !(mode_seen && !i2c_mode)) |=> $stable(bit_cnt));
  // R9
  ack_win_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> (bit_cnt == CNT_W'(8) || bit_cnt == CNT_W'(9)));
endmodule

bind ser_bitcnt ser_bitcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .i2c_mode(i2c_mode), .start_det(start_det),
  .clk_stop(clk_stop), .freeze(freeze), .bit_cnt(bit_cnt),
  .sda_pull_low(sda_pull_low)
);

// File: tb/sim_ser_bitcnt.sv
`timescale 1ns/1ps
module sim_ser_bitcnt;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_in = 1'b0, sda_in = 1'b1, i2c_mode = 1'b1, rx_dir = 1'b0;
  logic start_det = 1'b0, clk_stop = 1'b0, freeze = 1'b0;
  logic ack_wr_en = 1'b0, ack_wr_val = 1'b0;
  logic [3:0] bit_cnt;
  logic ack_bit, sda_pull_low;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ser_bitcnt u0 (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rise_half(); scl_in = 1'b1; tick(4); endtask
  task automatic fall_half(); scl_in = 1'b0; tick(4); endtask
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin rise_half(); fall_half(); end
  endtask

  task automatic pulse_sig(ref logic s);
    s = 1'b1; tick(1); s = 1'b0; tick(1);
  endtask

  task automatic write_ack(input logic v);
    ack_wr_val = v; ack_wr_en = 1'b1; tick(1); ack_wr_en = 1'b0; tick(1);
  endtask

  task automatic restart();
    pulse_sig(start_det);
    check("R5 start clears", bit_cnt, 0);
  endtask

  task automatic t_reset();
    check("R1 cnt", bit_cnt, 0);
    check("R1 ack", ack_bit, 1);
    check("R1 pull", sda_pull_low, 0);
  endtask

  task automatic t_latency();
    i2c_mode = 1'b1; restart();
    scl_in = 1'b1;
    tick(2);
    check("R2 not yet", bit_cnt, 0);
    tick(1);
    check("R2 third edge", bit_cnt, 1);
    tick(1); fall_half();
  endtask

  task automatic t_bus_wrap();
    i2c_mode = 1'b1; restart();
    pulses(9);
    check("R3 at 9", bit_cnt, 9);
    pulses(1);
    check("R3 wrap", bit_cnt, 0);
    pulses(2);
    check("R3 keeps counting", bit_cnt, 2);
  endtask

  task automatic t_shf_wrap();
    i2c_mode = 1'b0; tick(2);
    pulse_sig(clk_stop);
    check("R5 stop clears", bit_cnt, 0);
    pulses(8);
    check("R4 at 8", bit_cnt, 8);
    pulses(1);
    check("R4 wrap", bit_cnt, 0);
  endtask

  task automatic t_clears();
    i2c_mode = 1'b1; restart();
    pulses(5);
    check("R2 five", bit_cnt, 5);
    pulse_sig(clk_stop);
    check("R5 stop", bit_cnt, 0);
    pulses(4);
    pulse_sig(start_det);
    check("R5 start", bit_cnt, 0);
  endtask

  task automatic t_mode();
    i2c_mode = 1'b1; restart();
    pulses(5);
    i2c_mode = 1'b0; tick(1);
    check("R6 drop clears", bit_cnt, 0);
    pulses(3);
    i2c_mode = 1'b1; tick(2);
    check("R6 raise keeps", bit_cnt, 3);
  endtask

  task automatic t_freeze();
    i2c_mode = 1'b1; restart();
    pulses(2);
    freeze = 1'b1; tick(1);
    pulses(3);
    check("R7 held", bit_cnt, 2);
    freeze = 1'b0; tick(2);
    check("R7 no phantom", bit_cnt, 2);
    pulses(1);
    check("R7 resumes", bit_cnt, 3);
  endtask

  task automatic t_tx_capture();
    i2c_mode = 1'b1; rx_dir = 1'b0; write_ack(1'b1); restart();
    sda_in = 1'b0;
    pulses(8);
    check("R8 no early capture", ack_bit, 1);
    pulses(1);
    check("R8 captured low", ack_bit, 0);
    check("R10 held after frame", ack_bit, 0);
    sda_in = 1'b1; pulses(1); restart();
    pulses(9);
    check("R8 captured high", ack_bit, 1);
  endtask

  task automatic t_rx_drive(input logic v);
    i2c_mode = 1'b1; rx_dir = 1'b1; write_ack(v); restart();
    pulses(7); rise_half();
    check("R9 closed at 8 high", sda_pull_low, 0);
    fall_half();
    check("R9 open", sda_pull_low, !v);
    rise_half();
    check("R9 during 9", sda_pull_low, !v);
    fall_half();
    check("R9 closed", sda_pull_low, 0);
    check("R10 held", ack_bit, v);
    rx_dir = 1'b0;
  endtask

  task automatic t_shf_ack();
    i2c_mode = 1'b0; rx_dir = 1'b1; write_ack(1'b0); tick(2);
    pulse_sig(clk_stop);
    pulses(8);
    check("R11 no pull", sda_pull_low, 0);
    rx_dir = 1'b0; write_ack(1'b1); sda_in = 1'b0;
    pulses(1); pulses(9);
    check("R11 no capture", ack_bit, 1);
    sda_in = 1'b1;
  endtask

  initial begin
    tick(3); rst = 1'b0; tick(1);
    t_reset();
    t_latency();
    t_bus_wrap();
    t_shf_wrap();
    t_clears();
    t_mode();
    t_freeze();
    t_tx_capture();
    t_rx_drive(1'b0);
    t_rx_drive(1'b1);
    t_shf_ack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule